// File: doc/BRIEF.md
# Texture Fetch Rate Controller

This block sits in front of a texture filtering datapath and paces the work sent into it. Each fetch request arrives on a valid/ready channel and carries a 4-bit texel format code, a 2-bit filter mode and a fast-mode flag. From these fields the block works out how many datapath cycles the fetch needs. Texel depth, whether filtering really applies, how packed and half-float formats widen when filtered, trilinear doubling and a shortcut for wide float texels all feed into that number.

Once a request is accepted, the controller issues one beat per cycle downstream. Each beat carries an index and markers for the first and last beat. The request channel stays stalled until the final beat, so a queue of fetches streams with no idle cycle between them. Any format code outside the table sets a sticky error flag, and the fetch is then costed as a plain 32-bit point fetch.

Top module: `texfetch_rate_ctrl`

## Requirements
- R1: Format codes 0 (8-bit x1), 1 (8-bit x4), 2 (16-bit x2) and 4 (32-bit x1) are 32 bits deep and cost 1 cycle. Codes 3 (16-bit x4) and 5 (32-bit x2) are 64 bits deep and cost 2. Code 6 (32-bit x4) is 128 bits deep and costs 4. These costs apply to point and bilinear fetches. Filter mode 0 is point and mode 1 is bilinear.
- R2: The packed 32-bit codes 7 (11:11:10 class) and 8 (10:10:10:2 class) cost 1 cycle as point fetches and 2 cycles when filtered.
- R3: The half-float codes 9 (x1), 10 (x2) and 11 (x4) cost 1, 2 and 4 cycles when filtered. As point fetches they are costed by texel depth: 1, 1 and 2.
- R4: The full-float codes 12 (x1), 13 (x2) and 14 (x4) ignore the filter mode and cost 1, 2 and 4. With the fast flag set, code 14 costs 2.
- R5: Filter modes 2 and 3 select trilinear, which doubles the filtered cost of any format that R1 to R3 allow to be filtered. This gives a maximum cost of 8.
- R6: Code 15 is unlisted. It costs 1 cycle in every filter mode, and its acceptance sets `fmt_err`, which stays high until reset.
- R7: The beats of a fetch have `beat_idx` counting 0 through cost-1 on consecutive cycles. `beat_first` is high only at index 0, and `beat_last` is high only at index cost-1.
- R8: `req_ready` is high when no beat is in flight and during the last beat, and low during every other beat. A request that is pending at the last beat therefore starts its first beat on the very next cycle.
- R9: The first beat of an accepted request appears in the cycle after the handshake edge.
- R10: While `rst_n` is low, `beat_valid` and `fmt_err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_fmt | input | 4 | Texel format code |
| req_filt | input | 2 | Filter mode: 0 point, 1 bilinear, 2/3 trilinear |
| req_fast | input | 1 | Fast path for four-component full-float texels |
| beat_valid | output | 1 | A datapath beat is issued this cycle |
| beat_idx | output | $clog2(MAX_COST) | Index of the current beat |
| beat_first | output | 1 | Current beat is the first of its fetch |
| beat_last | output | 1 | Current beat is the last of its fetch |
| fmt_err | output | 1 | Sticky flag: an unlisted format was accepted |

## Verification
The bench builds the block with the default MAX_COST of 8. That is the smallest value that holds the 8-cycle trilinear cost of the widest formats, so every beat index from 0 to 7 and the full 3-bit index field are exercised. A directed sweep runs every format, filter mode and fast-flag combination back to back, which covers the no-bubble handover between fetches. Random requests with idle gaps then follow, and a reset applied mid-run confirms that the sticky error flag clears.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

  localparam int FMT_W  = 4;
  localparam int FILT_W = 2;

  typedef enum logic [2:0] {
    KIND_INT,
    KIND_PACKED,
    KIND_HALF,
    KIND_FULL,
    KIND_BAD
  } fmt_kind_e;

  // depth_lg: 0 = up to 32 bits, 1 = 64 bits, 2 = 128 bits
  // comp_lg : log2 of the component count
  typedef struct packed {
    fmt_kind_e   kind;
    logic [1:0]  depth_lg;
    logic [1:0]  comp_lg;
  } fmt_info_t;

endpackage

// File: rtl/tfr_fmt_decode.sv
module tfr_fmt_decode
  import tfr_pkg::*;
(
  input  logic [FMT_W-1:0] fmt,
  output fmt_info_t        info
);

  always_comb begin
    info = '{kind: KIND_BAD, depth_lg: 2'd0, comp_lg: 2'd0};
    case (fmt)
      4'd0:  info = '{kind: KIND_INT,    depth_lg: 2'd0, comp_lg: 2'd0};
      4'd1:  info = '{kind: KIND_INT,    depth_lg: 2'd0, comp_lg: 2'd2};
      4'd2:  info = '{kind: KIND_INT,    depth_lg: 2'd0, comp_lg: 2'd1};
      4'd3:  info = '{kind: KIND_INT,    depth_lg: 2'd1, comp_lg: 2'd2};
      4'd4:  info = '{kind: KIND_INT,    depth_lg: 2'd0, comp_lg: 2'd0};
      4'd5:  info = '{kind: KIND_INT,    depth_lg: 2'd1, comp_lg: 2'd1};
      4'd6:  info = '{kind: KIND_INT,    depth_lg: 2'd2, comp_lg: 2'd2};
      4'd7:  info = '{kind: KIND_PACKED, depth_lg: 2'd0, comp_lg: 2'd2};
      4'd8:  info = '{kind: KIND_PACKED, depth_lg: 2'd0, comp_lg: 2'd2};
      4'd9:  info = '{kind: KIND_HALF,   depth_lg: 2'd0, comp_lg: 2'd0};
      4'd10: info = '{kind: KIND_HALF,   depth_lg: 2'd0, comp_lg: 2'd1};
      4'd11: info = '{kind: KIND_HALF,   depth_lg: 2'd1, comp_lg: 2'd2};
      4'd12: info = '{kind: KIND_FULL,   depth_lg: 2'd0, comp_lg: 2'd0};
      4'd13: info = '{kind: KIND_FULL,   depth_lg: 2'd1, comp_lg: 2'd1};
      4'd14: info = '{kind: KIND_FULL,   depth_lg: 2'd2, comp_lg: 2'd2};
      default: info = '{kind: KIND_BAD,  depth_lg: 2'd0, comp_lg: 2'd0};
    endcase
  end

endmodule

// File: rtl/tfr_cost_calc.sv
module tfr_cost_calc
  import tfr_pkg::*;
#(
  parameter int COST_W = 4
) (
  input  fmt_info_t         info,
  input  logic [FILT_W-1:0] filt,
  input  logic              fast,
  output logic [COST_W-1:0] cost,
  output logic              bad
);

  logic       filt_req;
  logic       tri_req;
  logic       filt_ok;
  logic [1:0] base_lg;
  logic [1:0] cost_lg;

  assign filt_req = (filt != '0);
  assign tri_req  = filt[1];

  // Full-float and unknown formats never filter
  always_comb begin
    filt_ok = filt_req;
    base_lg = info.depth_lg;
    case (info.kind)
      KIND_INT:    base_lg = info.depth_lg;
      KIND_PACKED: base_lg = filt_req ? 2'd1 : 2'd0;
      KIND_HALF:   base_lg = filt_req ? info.comp_lg : info.depth_lg;
      KIND_FULL: begin
        filt_ok = 1'b0;
        base_lg = (fast && info.comp_lg == 2'd2) ? 2'd1 : info.depth_lg;
      end
      default: begin
        filt_ok = 1'b0;
        base_lg = 2'd0;
      end
    endcase
  end

  assign cost_lg = (filt_ok && tri_req) ? base_lg + 2'd1 : base_lg;
  assign cost    = COST_W'(1) << cost_lg;
  assign bad     = (info.kind == KIND_BAD);

endmodule

// File: rtl/tfr_beat_seq.sv
module tfr_beat_seq #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] last_idx_in,
  output logic             req_ready,
  output logic             accept,
  output logic             beat_valid,
  output logic [IDX_W-1:0] beat_idx,
  output logic             beat_first,
  output logic             beat_last
);

  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] lim_q, lim_d;
  logic             at_end;
  logic             seq_en;

  assign at_end    = active_q && (idx_q == lim_q);
  assign req_ready = !active_q || at_end;
  assign accept    = req_valid && req_ready;
  assign seq_en    = accept || active_q;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    lim_d    = lim_q;
    if (accept) begin
      active_d = 1'b1;
      idx_d    = '0;
      lim_d    = last_idx_in;
    end else if (at_end) begin
      active_d = 1'b0;
    end else if (active_q) begin
      idx_d    = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      lim_q    <= '0;
    end else if (seq_en) begin
      active_q <= active_d;
      idx_q    <= idx_d;
      lim_q    <= lim_d;
    end
  end

  assign beat_valid = active_q;
  assign beat_idx   = idx_q;
  assign beat_first = active_q && (idx_q == '0);
  assign beat_last  = at_end;

endmodule

// File: rtl/texfetch_rate_ctrl.sv
module texfetch_rate_ctrl
  import tfr_pkg::*;
#(
  parameter int MAX_COST = 8,
  localparam int IDX_W  = $clog2(MAX_COST),
  localparam int COST_W = $clog2(MAX_COST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FMT_W-1:0]  req_fmt,
  input  logic [FILT_W-1:0] req_filt,
  input  logic              req_fast,
  output logic              beat_valid,
  output logic [IDX_W-1:0]  beat_idx,
  output logic              beat_first,
  output logic              beat_last,
  output logic              fmt_err
);

  fmt_info_t         info;
  logic [COST_W-1:0] cost;
  logic [COST_W-1:0] cost_m1;
  logic              bad_fmt;
  logic              accept;
  logic              err_q, err_d, err_en;

  tfr_fmt_decode u_decode (
    .fmt  (req_fmt),
    .info (info)
  );

  tfr_cost_calc #(.COST_W(COST_W)) u_cost (
    .info (info),
    .filt (req_filt),
    .fast (req_fast),
    .cost (cost),
    .bad  (bad_fmt)
  );

  assign cost_m1 = cost - 1'b1;

  tfr_beat_seq #(.IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .last_idx_in (cost_m1[IDX_W-1:0]),
    .req_ready   (req_ready),
    .accept      (accept),
    .beat_valid  (beat_valid),
    .beat_idx    (beat_idx),
    .beat_first  (beat_first),
    .beat_last   (beat_last)
  );

  assign err_en = accept && bad_fmt;
  assign err_d  = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign fmt_err = err_q;

endmodule

// File: rtl/tfr_checker.sv
module tfr_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [3:0]       req_fmt,
  input logic             beat_valid,
  input logic [IDX_W-1:0] beat_idx,
  input logic             beat_first,
  input logic             beat_last,
  input logic             fmt_err
);

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (beat_valid && beat_first && beat_idx == '0)); // R9

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |-> !req_ready); // R8

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> req_ready); // R8

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> (beat_valid && beat_idx == IDX_W'($past(beat_idx) + 1'b1))); // R7

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && !req_valid) |=> !beat_valid); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err); // R6

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fmt_err) |-> $past(req_valid && req_ready && req_fmt == 4'd15)); // R6

endmodule

bind texfetch_rate_ctrl tfr_checker #(.IDX_W(IDX_W)) u_tfr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_fmt    (req_fmt),
  .beat_valid (beat_valid),
  .beat_idx   (beat_idx),
  .beat_first (beat_first),
  .beat_last  (beat_last),
  .fmt_err    (fmt_err)
);

// File: tb/test_texfetch_rate_ctrl.sv
module test_texfetch_rate_ctrl;

  localparam int MAX_COST = 8;
  localparam int IDX_W    = $clog2(MAX_COST);

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic [3:0]       req_fmt;
  logic [1:0]       req_filt;
  logic             req_fast;
  logic             beat_valid;
  logic [IDX_W-1:0] beat_idx;
  logic             beat_first;
  logic             beat_last;
  logic             fmt_err;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  texfetch_rate_ctrl #(.MAX_COST(MAX_COST)) i_texfetch_rate_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_fmt    (req_fmt),
    .req_filt   (req_filt),
    .req_fast   (req_fast),
    .beat_valid (beat_valid),
    .beat_idx   (beat_idx),
    .beat_first (beat_first),
    .beat_last  (beat_last),
    .fmt_err    (fmt_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Expected cost, written from the requirement tables
  function automatic int exp_cost(input logic [3:0] f, input logic [1:0] m, input logic fst);
    bit filt = (m != 2'd0);
    bit tri3 = m[1];
    case (f)
      4'd0, 4'd1, 4'd2, 4'd4: return tri3 ? 2 : 1;   // R1, R5
      4'd3, 4'd5:             return tri3 ? 4 : 2;   // R1, R5
      4'd6:                   return tri3 ? 8 : 4;   // R1, R5
      4'd7, 4'd8:             return !filt ? 1 : (tri3 ? 4 : 2); // R2
      4'd9:                   return tri3 ? 2 : 1;   // R3
      4'd10:                  return !filt ? 1 : (tri3 ? 4 : 2); // R3
      4'd11:                  return !filt ? 2 : (tri3 ? 8 : 4); // R3
      4'd12:                  return 1;              // R4
      4'd13:                  return 2;              // R4
      4'd14:                  return fst ? 2 : 4;    // R4
      default:                return 1;              // R6
    endcase
  endfunction

  function automatic string cost_tag(input logic [3:0] f, input logic [1:0] m);
    if (f == 4'd15) return "R6";
    if (f >= 4'd12) return "R4";
    if (f >= 4'd9)  return "R3";
    if (f >= 4'd7)  return "R2";
    if (m[1])       return "R5";
    return "R1";
  endfunction

  // Reference model of the beat stream, updated at each falling edge
  bit    m_active = 0;
  int    m_idx    = 0;
  int    m_cost   = 1;
  bit    m_err    = 0;
  string m_tag    = "R1";

  always @(negedge clk) begin
    if (!rst_n) begin
      check(beat_valid == 1'b0, "R10", "beat_valid in reset", beat_valid, 0);
      check(fmt_err == 1'b0,    "R10", "fmt_err in reset", fmt_err, 0);
      check(req_ready == 1'b1,  "R10", "req_ready in reset", req_ready, 1);
      m_active = 0; m_idx = 0; m_cost = 1; m_err = 0;
    end else begin
      bit exp_last;
      bit exp_ready;
      check(beat_valid == m_active, "R9", "beat_valid", beat_valid, m_active);
      exp_last  = m_active && (m_idx == m_cost - 1);
      exp_ready = !m_active || exp_last;
      if (m_active) begin
        check(int'(beat_idx) == m_idx, "R7", "beat_idx", beat_idx, m_idx);
        check(beat_first == (m_idx == 0), "R7", "beat_first", beat_first, m_idx == 0);
        check(beat_last == exp_last, m_tag, "beat_last (cost)", beat_last, exp_last);
      end
      check(req_ready == exp_ready, "R8", "req_ready", req_ready, exp_ready);
      check(fmt_err == m_err, "R6", "fmt_err", fmt_err, m_err);
      if (req_valid && exp_ready) begin
        m_active = 1; m_idx = 0;
        m_cost   = exp_cost(req_fmt, req_filt, req_fast);
        m_tag    = cost_tag(req_fmt, req_filt);
        if (req_fmt == 4'd15) m_err = 1;
      end else if (exp_last) begin
        m_active = 0;
      end else if (m_active) begin
        m_idx++;
      end
    end
  end

  // Present a request; returns at the falling edge before its handshake edge
  task automatic send(input logic [3:0] f, input logic [1:0] m, input logic fst, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); #1;
      req_valid = 1'b0;
    end
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_fmt   = f;
    req_filt  = m;
    req_fast  = fst;
    do @(negedge clk); while (!req_ready);
  endtask

  task automatic go_idle(input int n);
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd20251));
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_fmt   = '0;
    req_filt  = '0;
    req_fast  = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // Directed: a lone trilinear widest fetch covers index 7 (R5, R7)
    send(4'd6, 2'd2, 1'b0, 0);
    go_idle(12);
    // Fast flag on a 32-bit x4 integer format has no effect (R1)
    send(4'd6, 2'd0, 1'b1, 0);
    // Full-float x4 with fast flag, back to back (R4, R8)
    send(4'd14, 2'd2, 1'b1, 0);
    send(4'd14, 2'd1, 1'b0, 0);
    go_idle(6);

    // Directed sweep of every combination, streamed back to back
    for (int f = 0; f < 16; f++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++)
          send(4'(f), 2'(m), 1'(s), 0);
    go_idle(10);

    // Mid-run reset clears the sticky error (R10, R6)
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    go_idle(2);

    // Random stream with idle gaps
    for (int i = 0; i < 2000; i++) begin
      int gap;
      gap = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 3)) : 0;
      send(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), gap);
    end
    go_idle(12);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule